// File: doc/BRIEF.md
# Buffered Capture/Compare Timer Channel

This block is a single timer channel built around a free-running up-counter and a set of general registers (two by default). Each general register is set by its own mode bit to act either as a compare register or as a capture register. Each one has a buffer register of its own. The buffer turns the general register into a two-deep store, and the direction of that store depends on the mode. In compare mode a match refills the general register from the buffer, so software can queue the next compare value ahead of time. In capture mode a capture pushes the previous captured value down into the buffer, so the last two timestamps are held together.

Software reaches every register through a plain write port and a combinational read port, both on one small address map. Capture inputs are asynchronous and are synchronised inside the block. Compare matches come out as one-cycle pulses. A sticky status flag per general register records matches and captures until software clears it. All pins are plain control and status signals. None of the traffic is a stream, so there is no valid/ready handshake and nothing to back-pressure.

Top module: `buf_timer`

## Requirements
- R1: The 16-bit counter increments by one on each clock edge where `cnt_en` is high, wraps from 0xFFFF to 0x0000, and holds when `cnt_en` is low. A bus write to address 0 loads the counter and takes priority over the increment.
- R2: `match_out[i]` is high in exactly the cycles where register i is in compare mode (`cap_mode[i]`=0), `cnt_en` is high and the counter equals general register i. When buffering is on, the reloaded compare value is used from the next cycle.
- R3: In compare mode with `buf_en[i]`=1, a match copies buffer register i into general register i at the same clock edge.
- R4: In compare mode with `buf_en[i]`=0, a match leaves general register i unchanged.
- R5: In capture mode (`cap_mode[i]`=1), a selected edge on `cap_in[i]` loads general register i with the counter value. The input passes through a two-flop synchroniser, so the load happens at the third rising clock edge after the input changes, and the value loaded is the one the counter held just before that edge. Capture does not depend on `cnt_en`.
- R6: In capture mode with `buf_en[i]`=1, the same capture copies the value general register i held before the capture into buffer register i.
- R7: In capture mode with `buf_en[i]`=0, a capture leaves buffer register i unchanged.
- R8: `edge_sel[2i+1:2i]` selects the capture edge for register i: 0 means rising, 1 means falling, 2 or 3 means both edges. An edge that is not selected causes no capture.
- R9: A hardware transfer into a general or buffer register (a capture, or a buffered reload) overrides a bus write to that same register in the same cycle.
- R10: `flags[i]` is set by a match or a capture on register i. Writing 1 to bit i at address 5 clears it. A set in the same cycle as a clear wins.
- R11: After reset the counter, all general and buffer registers, and the flags read as zero.
- R12: Address map for reads and writes: 0 is the counter, 1 and 2 are general registers 0 and 1, 3 and 4 are buffer registers 0 and 1 (paired 1↔3 and 2↔4), and 5 holds the flags in bits [1:0]. An unused address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter tick enable |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 3 | Bus write address |
| wr_data | input | 16 | Bus write data |
| rd_addr | input | 3 | Bus read address |
| rd_data | output | 16 | Combinational read data |
| cap_mode | input | 2 | Per register: 1 = capture, 0 = compare |
| buf_en | input | 2 | Per register buffer enable |
| edge_sel | input | 4 | Two bits per register selecting the capture edge |
| cap_in | input | 2 | Asynchronous capture inputs |
| match_out | output | 2 | Compare match pulses |
| flags | output | 2 | Sticky match/capture flags |

## Verification
The bench aims capture edges at exact cycles so that a bus write to a buffer register lands on the same edge as the hardware push-down. A design with the wrong priority would keep the software value and lose the previous timestamp. It runs the counter through 0xFFFF and matches at the wrap. A design that stalled or saturated there would never match again. Compare registers are driven with buffering on and off. A design that reloaded regardless of `buf_en` would corrupt an unbuffered compare value, and one that missed the reload would match the same value again on the next pass. Each of the edge selections is tried against the opposite edge, and flags are cleared in the same cycle as a fresh event, to catch an inverted selector or a clear that beats a set.

// File: rtl/buf_timer_pkg.sv
package buf_timer_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'b00,
    EDGE_FALL  = 2'b01,
    EDGE_ANY   = 2'b10,
    EDGE_ANY2  = 2'b11
  } edge_sel_e;

  function automatic logic edge_hit(input edge_sel_e sel, input logic cur, input logic prev);
    case (sel)
      EDGE_RISE: return cur & ~prev;
      EDGE_FALL: return ~cur & prev;
      default:   return cur ^ prev;
    endcase
  endfunction

endpackage

// File: rtl/bt_counter.sv
module bt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= count + CNT_W'(1);
  end

endmodule

// File: rtl/bt_edge_sync.sv
module bt_edge_sync
  import buf_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig_in,
  input  logic [1:0] sel,
  output logic       strobe
);

  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= sig_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign strobe = edge_hit(edge_sel_e'(sel), sync_q, prev_q);

endmodule

// File: rtl/bt_channel.sv
module bt_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             tick,
  input  logic             cap_mode,
  input  logic             buf_en,
  input  logic             cap_stb,
  input  logic             gr_we,
  input  logic             buf_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] gr,
  output logic [CNT_W-1:0] bf,
  output logic             match,
  output logic             flag
);

  logic capture;

  assign match   = ~cap_mode & tick & (count == gr);
  assign capture = cap_mode & cap_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gr <= '0;
    else if (capture)          gr <= count;
    else if (match && buf_en)  gr <= bf;
    else if (gr_we)            gr <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  bf <= '0;
    else if (capture && buf_en)  bf <= gr;
    else if (buf_we)             bf <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flag <= 1'b0;
    else if (match || capture)   flag <= 1'b1;
    else if (flag_clr)           flag <= 1'b0;
  end

endmodule

// File: rtl/buf_timer.sv
module buf_timer #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_en,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [CNT_W-1:0]    rd_data,
  input  logic [NUM_CH-1:0]   cap_mode,
  input  logic [NUM_CH-1:0]   buf_en,
  input  logic [2*NUM_CH-1:0] edge_sel,
  input  logic [NUM_CH-1:0]   cap_in,
  output logic [NUM_CH-1:0]   match_out,
  output logic [NUM_CH-1:0]   flags
);

  localparam int GR_BASE  = 1;
  localparam int BUF_BASE = GR_BASE + NUM_CH;
  localparam int FLAG_ADR = BUF_BASE + NUM_CH;

  logic [CNT_W-1:0]              count_q;
  logic [NUM_CH-1:0][CNT_W-1:0]  gr_q;
  logic [NUM_CH-1:0][CNT_W-1:0]  bf_q;
  logic [NUM_CH-1:0]             cap_stb;
  logic [NUM_CH-1:0]             gr_wr;
  logic [NUM_CH-1:0]             buf_wr;
  logic [NUM_CH-1:0]             flag_clr;
  logic                          cnt_wr;

  assign cnt_wr   = wr_en && (int'(wr_addr) == 0);
  assign flag_clr = (wr_en && (int'(wr_addr) == FLAG_ADR)) ? wr_data[NUM_CH-1:0] : '0;

  bt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (cnt_en),
    .load     (cnt_wr),
    .load_val (wr_data),
    .count    (count_q)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign gr_wr[i]  = wr_en && (int'(wr_addr) == GR_BASE + i);
    assign buf_wr[i] = wr_en && (int'(wr_addr) == BUF_BASE + i);

    bt_edge_sync u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (cap_in[i]),
      .sel    (edge_sel[2*i +: 2]),
      .strobe (cap_stb[i])
    );

    bt_channel #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .count    (count_q),
      .tick     (cnt_en),
      .cap_mode (cap_mode[i]),
      .buf_en   (buf_en[i]),
      .cap_stb  (cap_stb[i]),
      .gr_we    (gr_wr[i]),
      .buf_we   (buf_wr[i]),
      .wdata    (wr_data),
      .flag_clr (flag_clr[i]),
      .gr       (gr_q[i]),
      .bf       (bf_q[i]),
      .match    (match_out[i]),
      .flag     (flags[i])
    );
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) == 0) rd_data = count_q;
    if (int'(rd_addr) == FLAG_ADR) rd_data = CNT_W'(flags);
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(rd_addr) == GR_BASE + i)  rd_data = gr_q[i];
      if (int'(rd_addr) == BUF_BASE + i) rd_data = bf_q[i];
    end
  end

endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cnt_en,
  input logic                       cnt_wr,
  input logic [CNT_W-1:0]           count,
  input logic [NUM_CH-1:0]          cap_mode,
  input logic [NUM_CH-1:0]          buf_en,
  input logic [NUM_CH-1:0]          cap_stb,
  input logic [NUM_CH-1:0]          gr_wr,
  input logic [NUM_CH-1:0]          match_out,
  input logic [NUM_CH-1:0]          flags,
  input logic [NUM_CH-1:0][CNT_W-1:0] gr,
  input logic [NUM_CH-1:0][CNT_W-1:0] bf
);

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && !cnt_wr && (count == '1) |=> count == '0); // R1

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en && !cnt_wr |=> $stable(count)); // R1

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ast
    AST_MATCH_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      match_out[i] && buf_en[i] |=> gr[i] == $past(bf[i])); // R3

    AST_MATCH_NOBUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      match_out[i] && !buf_en[i] && !gr_wr[i] |=> $stable(gr[i])); // R4

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cap_mode[i] && cap_stb[i] |=> gr[i] == $past(count)); // R5

    AST_CAPTURE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      cap_mode[i] && cap_stb[i] && buf_en[i] |=> bf[i] == $past(gr[i])); // R6

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      match_out[i] || (cap_mode[i] && cap_stb[i]) |=> flags[i]); // R10
  end

endmodule

bind buf_timer bt_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_en    (cnt_en),
  .cnt_wr    (cnt_wr),
  .count     (count_q),
  .cap_mode  (cap_mode),
  .buf_en    (buf_en),
  .cap_stb   (cap_stb),
  .gr_wr     (gr_wr),
  .match_out (match_out),
  .flags     (flags),
  .gr        (gr_q),
  .bf        (bf_q)
);

// File: tb/tb_buf_timer.sv
module tb_buf_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  cap_mode = '0;
  logic [1:0]  buf_en = '0;
  logic [3:0]  edge_sel = '0;
  logic [1:0]  cap_in = '0;
  logic [1:0]  match_out;
  logic [1:0]  flags;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  buf_timer dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cap_mode(cap_mode),
    .buf_en(buf_en), .edge_sel(edge_sel), .cap_in(cap_in), .match_out(match_out),
    .flags(flags)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_cnt;
  logic [15:0] m_gr [2];
  logic [15:0] m_bf [2];
  logic [1:0]  m_flag;
  logic [1:0]  hist [$];

  function automatic bit sel_edge(input logic [1:0] s, input logic cur, input logic prv);
    if (s == 2'd0) return cur && !prv;
    if (s == 2'd1) return !cur && prv;
    return cur != prv;
  endfunction

  function automatic logic [15:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt;
      3'd1: return m_gr[0];
      3'd2: return m_gr[1];
      3'd3: return m_bf[0];
      3'd4: return m_bf[1];
      3'd5: return {14'd0, m_flag};
      default: return 16'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_gr[0] = 0; m_gr[1] = 0; m_bf[0] = 0; m_bf[1] = 0; m_flag = 0;
      hist = '{2'b00, 2'b00, 2'b00};
    end else begin
      logic [15:0] ngr [2];
      logic [15:0] nbf [2];
      logic [1:0]  nfl;
      for (int i = 0; i < 2; i++) begin
        bit stb, mt, cap;
        stb = sel_edge(edge_sel[2*i +: 2], hist[1][i], hist[2][i]);
        mt  = !cap_mode[i] && cnt_en && (m_cnt == m_gr[i]);
        cap = cap_mode[i] && stb;
        ngr[i] = m_gr[i]; nbf[i] = m_bf[i]; nfl[i] = m_flag[i];
        if (wr_en && wr_addr == 3'(1 + i)) ngr[i] = wr_data;
        if (wr_en && wr_addr == 3'(3 + i)) nbf[i] = wr_data;
        if (wr_en && wr_addr == 3'd5 && wr_data[i]) nfl[i] = 1'b0;
        if (mt && buf_en[i]) ngr[i] = m_bf[i];
        if (cap) begin
          ngr[i] = m_cnt;
          if (buf_en[i]) nbf[i] = m_gr[i];
        end
        if (mt || cap) nfl[i] = 1'b1;
      end
      if (wr_en && wr_addr == 3'd0) m_cnt = wr_data;
      else if (cnt_en) m_cnt = m_cnt + 16'd1;
      for (int i = 0; i < 2; i++) begin
        m_gr[i] = ngr[i]; m_bf[i] = nbf[i]; m_flag[i] = nfl[i];
      end
      hist.push_front(cap_in);
      void'(hist.pop_back());
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %h expected %h", req, $time, got, exp);
    end
  endtask

  // compare against the model on every clock, after the edge has settled
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic [1:0] em;
      for (int i = 0; i < 2; i++)
        em[i] = !cap_mode[i] && cnt_en && (m_cnt == m_gr[i]);
      chk("R2 match_out", {14'd0, match_out}, {14'd0, em});
      chk("R10 flags", {14'd0, flags}, {14'd0, m_flag});
      chk("R12 rd_data", rd_data, model_read(rd_addr));
    end
  end

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic peek(input string req, input logic [2:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      rd_addr = 3'(a);
      #1;
      chk("R11 reset value", rd_data, 16'd0);
    end
    rst_n = 1'b1;
    tick(2);

    // R3: buffered compare reload
    cap_mode = 2'b00; buf_en = 2'b01;
    bus_wr(3'd1, 16'd5);
    bus_wr(3'd3, 16'd9);
    bus_wr(3'd2, 16'd7);
    bus_wr(3'd4, 16'd3);
    bus_wr(3'd0, 16'd0);
    cnt_en = 1'b1;
    tick(12);
    cnt_en = 1'b0;
    peek("R3 reloaded GR0", 3'd1, 16'd9);
    peek("R4 unbuffered GR1 kept", 3'd2, 16'd7);
    peek("R10 flags set", 3'd5, 16'd3);
    bus_wr(3'd5, 16'd1);
    peek("R10 flag0 cleared", 3'd5, 16'd2);
    bus_wr(3'd5, 16'd2);

    // R1: wrap through 0xFFFF, and a match at the wrap point
    bus_wr(3'd1, 16'd0);
    bus_wr(3'd3, 16'd2);
    bus_wr(3'd0, 16'hFFFE);
    cnt_en = 1'b1;
    tick(3);
    cnt_en = 1'b0;
    peek("R1 counter wrapped", 3'd0, 16'd1);
    peek("R3 reload at wrap", 3'd1, 16'd2);
    tick(2);
    peek("R1 counter holds", 3'd0, 16'd1);

    // R5/R6: buffered capture, counter frozen
    bus_wr(3'd5, 16'd3);
    cap_mode = 2'b01; buf_en = 2'b01; edge_sel = 4'b0000;
    bus_wr(3'd1, 16'h0055);
    bus_wr(3'd0, 16'h1234);
    cap_in[0] = 1'b1;
    tick(2);
    peek("R5 no capture before sync", 3'd1, 16'h0055);
    tick(1);
    peek("R5 capture loads counter", 3'd1, 16'h1234);
    peek("R6 old value pushed", 3'd3, 16'h0055);
    // R8: falling edge not selected on rising mode
    cap_in[0] = 1'b0;
    tick(4);
    peek("R8 falling edge ignored", 3'd1, 16'h1234);

    // R9: bus write to buffer on the same edge as the push-down
    bus_wr(3'd0, 16'h4321);
    cap_in[0] = 1'b1;
    tick(2);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'hBEEF;
    tick(1);
    wr_en = 1'b0;
    peek("R9 push overrides bus write", 3'd3, 16'h1234);
    peek("R5 second capture", 3'd1, 16'h4321);

    // R7/R8: register 1 capture on falling edge, no buffering
    cap_mode = 2'b10; buf_en = 2'b00; edge_sel = 4'b0100;
    bus_wr(3'd4, 16'h0AAA);
    bus_wr(3'd2, 16'h0077);
    bus_wr(3'd0, 16'h0100);
    cap_in[1] = 1'b1;
    tick(4);
    peek("R8 rising ignored in falling mode", 3'd2, 16'h0077);
    bus_wr(3'd0, 16'h0200);
    cap_in[1] = 1'b0;
    tick(4);
    peek("R8 falling edge captured", 3'd2, 16'h0200);
    peek("R7 buffer untouched", 3'd4, 16'h0AAA);

    // R8: both edges on register 0
    cap_mode = 2'b11; buf_en = 2'b11; edge_sel = 4'b1011;
    bus_wr(3'd0, 16'h0300);
    cap_in[0] = 1'b0;
    tick(4);
    peek("R8 both-edge fall", 3'd1, 16'h0300);
    bus_wr(3'd0, 16'h0400);
    cap_in[0] = 1'b1;
    tick(4);
    peek("R8 both-edge rise", 3'd1, 16'h0400);
    peek("R6 push on both-edge", 3'd3, 16'h0300);

    // random phase, model compared every clock
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom;
      cnt_en = (r % 4) != 0;
      if ((r >> 3) % 7 == 0) cap_in = 2'($urandom);
      if ((r >> 6) % 50 == 0) begin
        cap_mode = 2'($urandom); buf_en = 2'($urandom); edge_sel = 4'($urandom);
      end
      wr_en = ((r >> 12) % 5) == 0;
      wr_addr = 3'($urandom % 7);
      wr_data = ((r >> 16) % 3 == 0) ? 16'($urandom % 64) : 16'($urandom);
      rd_addr = 3'($urandom % 7);
      tick(1);
    end
    wr_en = 1'b0;
    tick(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule